// File: doc/BRIEF.md
# Prescaled Timer with Match and Capture Channels

This block is a free-running timer for a peripheral bus. A prescaler divides the clock, and the main counter advances once every (prescale + 1) clocks. Four compare channels watch the counter. When the counter reaches a compare value, a channel can post an event, send the counter back to zero, or halt counting. Four capture inputs pass through a synchronizer. A selected edge on an input copies the current count into that channel's capture register.

Software drives the block through a word-addressed register bus with a one-cycle read latency. Events from the compare and capture channels collect in one sticky flag register, and one interrupt line reports whether any flag is pending. Software clears a flag by writing a one to its bit.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, every register reads as zero, and `irq` and `bus_rdata` are zero.
- R2: While control bit 1 is set, the timer counter and the prescale counter stay at zero, whatever the enable bit holds.
- R3: While control bit 0 is set, the prescale counter steps from 0 up to the prescale value. On the clock where it equals that value, it wraps to 0 and the timer counter advances by one. While bit 0 is clear, both counters hold their values.
- R4: On a counter-advance clock where the timer counter equals compare value n, and match-control bit 3n is set, flag bit n is set.
- R5: In the same situation with match-control bit 3n+1 set, the timer counter goes to 0 instead of to the compare value plus one.
- R6: In the same situation with match-control bit 3n+2 set, control bit 0 is cleared. The counter keeps the value that this last advance produced.
- R7: Capture input n is synchronized by two flops. A rising edge (capture-control bit 3n) or a falling edge (bit 3n+1) copies the current timer counter into capture register n. With both bits set, every transition is captured. An edge whose bit is clear has no effect.
- R8: A capture load on channel n sets flag bit 4+n only when capture-control bit 3n+2 is set. No flag is set on a match or a capture whose interrupt bit is clear.
- R9: Writing a one to a flag bit clears it, and writing a zero leaves it unchanged. When a new event and a clear of the same bit fall in the same clock, the bit stays set.
- R10: `irq` is high exactly when at least one flag bit is set, and it changes on the same clock as the flags.
- R11: Word addresses are 0 flags, 1 control, 2 timer counter, 3 prescale value, 4 prescale counter, 5 match control, 6 to 9 compare values 0 to 3, 10 capture control, and 11 to 14 capture registers 0 to 3. A bus write loads the counters and the configuration registers. Capture registers ignore writes. `bus_rdata` shows the addressed register one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| cap_in | input | NUM_CAP | Asynchronous capture inputs |
| irq | output | 1 | High while any flag is pending |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, four compare channels, four capture channels and a two-flop synchronizer. With these values every register sits at the address the requirements decode. It writes prescale values of 0 and 2 at run time, so that wraps, compare resets and stops happen within a few dozen clocks and give exact counter values. Because the synchronizer depth is fixed at two, the bench can place a flag clear on the same clock as a capture event and check that the event wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Register word offsets shared by decode and bench documentation
  localparam int OFS_FLAG   = 0;
  localparam int OFS_CTRL   = 1;
  localparam int OFS_TC     = 2;
  localparam int OFS_PR     = 3;
  localparam int OFS_PC     = 4;
  localparam int OFS_MCTL   = 5;
  localparam int OFS_MATCH0 = 6;

  // Control register bit positions
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_HOLD = 1;

  // Per-channel compare action field, bit 0 = event, 1 = zero, 2 = halt
  typedef struct packed {
    logic halt;
    logic zero;
    logic evt;
  } mch_cfg_t;

  // Per-channel capture field, bit 0 = rising, 1 = falling, 2 = event
  typedef struct packed {
    logic evt;
    logic fall;
    logic rise;
  } cch_cfg_t;

endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             hold,
  input  logic             wr_tc,
  input  logic             wr_pc,
  input  logic             wrap_zero,
  input  logic [CNT_W-1:0] pr,
  input  logic [CNT_W-1:0] wdata,
  output logic             tick,
  output logic [CNT_W-1:0] tc,
  output logic [CNT_W-1:0] pc
);

  // Wrap also when pc sits above a newly lowered prescale value
  assign tick = run && !hold && (pc >= pr);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      tc <= '0;
      pc <= '0;
    end else begin
      if (wr_pc)     pc <= wdata;
      else if (tick) pc <= '0;
      else if (run)  pc <= pc + 1'b1;

      if (wr_tc)     tc <= wdata;
      else if (tick) tc <= wrap_zero ? '0 : tc + 1'b1;
    end
  end

  // R2
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (tc == '0 && pc == '0));

  // R3
  pc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_pc) |=> (pc == '0));

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !hold && !tick && !wr_pc) |=> (pc == $past(pc) + 1'b1));

  // R3
  tc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !hold && !wr_tc) |=> $stable(tc));

endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank #(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 4
) (
  input  logic                   tick,
  input  logic [CNT_W-1:0]       tc,
  input  logic [CNT_W-1:0]       match_val [NUM_MATCH],
  input  logic [3*NUM_MATCH-1:0] mctl,
  output logic [NUM_MATCH-1:0]   evt_set,
  output logic                   wrap_zero,
  output logic                   halt_req
);

  logic [NUM_MATCH-1:0] zero_hit;
  logic [NUM_MATCH-1:0] halt_hit;

  for (genvar n = 0; n < NUM_MATCH; n++) begin : g_ch
    tmr_pkg::mch_cfg_t cfg;
    logic              hit;
    assign cfg         = mctl[3*n +: 3];
    assign hit         = tick && (tc == match_val[n]);
    assign evt_set[n]  = hit && cfg.evt;
    assign zero_hit[n] = hit && cfg.zero;
    assign halt_hit[n] = hit && cfg.halt;
  end

  assign wrap_zero = |zero_hit;
  assign halt_req  = |halt_hit;

endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_in,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic [CNT_W-1:0] tc,
  output logic             load,
  output logic [CNT_W-1:0] cap_q
);

  // Stages 0..SYNC_STAGES-1 synchronize, the last one holds the old level
  logic [SYNC_STAGES:0] shr;
  logic                 cur;
  logic                 prev;

  always_ff @(posedge clk) begin
    if (rst) shr <= '0;
    else     shr <= {shr[SYNC_STAGES-1:0], cap_in};
  end

  assign cur  = shr[SYNC_STAGES-1];
  assign prev = shr[SYNC_STAGES];
  assign load = (rise_en && cur && !prev) || (fall_en && !cur && prev);

  always_ff @(posedge clk) begin
    if (rst)       cap_q <= '0;
    else if (load) cap_q <= tc;
  end

  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cap_q));

  // R7
  cap_copy_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cap_q == $past(tc)));

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CNT_W       = 32,
  parameter int NUM_MATCH   = 4,
  parameter int NUM_CAP     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  input  logic [NUM_CAP-1:0] cap_in,
  output logic               irq
);
  import tmr_pkg::*;

  localparam int FLAG_W   = NUM_MATCH + NUM_CAP;
  localparam int OFS_CCTL = OFS_MATCH0 + NUM_MATCH;
  localparam int OFS_CAP0 = OFS_CCTL + 1;

  int addr_i;
  assign addr_i = int'(bus_addr);

  logic [1:0]             ctrl_q;
  logic [CNT_W-1:0]       pr_q;
  logic [3*NUM_MATCH-1:0] mctl_q;
  logic [3*NUM_CAP-1:0]   cctl_q;
  logic [CNT_W-1:0]       match_q [NUM_MATCH];
  logic [FLAG_W-1:0]      flags_q, flags_d, clr_vec, set_vec;
  logic [CNT_W-1:0]       rd_mux;

  logic wr_flag, wr_ctrl, wr_tc, wr_pr, wr_pc, wr_mctl, wr_cctl;
  assign wr_flag = bus_we && addr_i == OFS_FLAG;
  assign wr_ctrl = bus_we && addr_i == OFS_CTRL;
  assign wr_tc   = bus_we && addr_i == OFS_TC;
  assign wr_pr   = bus_we && addr_i == OFS_PR;
  assign wr_pc   = bus_we && addr_i == OFS_PC;
  assign wr_mctl = bus_we && addr_i == OFS_MCTL;
  assign wr_cctl = bus_we && addr_i == OFS_CCTL;

  // Counter core
  logic             tick, wrap_zero, halt_req;
  logic [CNT_W-1:0] tc, pc;

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .run       (ctrl_q[CTRL_RUN]),
    .hold      (ctrl_q[CTRL_HOLD]),
    .wr_tc     (wr_tc),
    .wr_pc     (wr_pc),
    .wrap_zero (wrap_zero),
    .pr        (pr_q),
    .wdata     (bus_wdata),
    .tick      (tick),
    .tc        (tc),
    .pc        (pc)
  );

  // Compare channels
  logic [NUM_MATCH-1:0] match_set;

  tmr_match_bank #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_match (
    .tick      (tick),
    .tc        (tc),
    .match_val (match_q),
    .mctl      (mctl_q),
    .evt_set   (match_set),
    .wrap_zero (wrap_zero),
    .halt_req  (halt_req)
  );

  // Capture channels
  logic [NUM_CAP-1:0] cap_set;
  logic [NUM_CAP-1:0] cap_load;
  logic [CNT_W-1:0]   cap_val [NUM_CAP];

  for (genvar n = 0; n < NUM_CAP; n++) begin : g_cap
    cch_cfg_t cfg;
    assign cfg = cctl_q[3*n +: 3];

    tmr_capture_chan #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .cap_in  (cap_in[n]),
      .rise_en (cfg.rise),
      .fall_en (cfg.fall),
      .tc      (tc),
      .load    (cap_load[n]),
      .cap_q   (cap_val[n])
    );

    assign cap_set[n] = cap_load[n] && cfg.evt;
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pr_q   <= '0;
      mctl_q <= '0;
      cctl_q <= '0;
      for (int n = 0; n < NUM_MATCH; n++) match_q[n] <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[1:0];
      if (halt_req) ctrl_q[CTRL_RUN] <= 1'b0;
      if (wr_pr)   pr_q   <= bus_wdata;
      if (wr_mctl) mctl_q <= bus_wdata[3*NUM_MATCH-1:0];
      if (wr_cctl) cctl_q <= bus_wdata[3*NUM_CAP-1:0];
      for (int n = 0; n < NUM_MATCH; n++)
        if (bus_we && addr_i == OFS_MATCH0 + n) match_q[n] <= bus_wdata;
    end
  end

  // Flag register: set beats clear
  assign set_vec = {cap_set, match_set};

  always_comb begin
    clr_vec = wr_flag ? bus_wdata[FLAG_W-1:0] : '0;
    flags_d = (flags_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq     <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq     <= |flags_d;
    end
  end

  // Read path
  always_comb begin
    rd_mux = '0;
    if (addr_i == OFS_FLAG) rd_mux = CNT_W'(flags_q);
    if (addr_i == OFS_CTRL) rd_mux = CNT_W'(ctrl_q);
    if (addr_i == OFS_TC)   rd_mux = tc;
    if (addr_i == OFS_PR)   rd_mux = pr_q;
    if (addr_i == OFS_PC)   rd_mux = pc;
    if (addr_i == OFS_MCTL) rd_mux = CNT_W'(mctl_q);
    if (addr_i == OFS_CCTL) rd_mux = CNT_W'(cctl_q);
    for (int n = 0; n < NUM_MATCH; n++)
      if (addr_i == OFS_MATCH0 + n) rd_mux = match_q[n];
    for (int n = 0; n < NUM_CAP; n++)
      if (addr_i == OFS_CAP0 + n) rd_mux = cap_val[n];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R6
  halt_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !ctrl_q[CTRL_RUN]);

  // R5
  zero_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_zero && !wr_tc && !ctrl_q[CTRL_HOLD]) |=> (tc == '0));

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag_chk
    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> flags_q[i]);

    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_flag && bus_wdata[i] && !set_vec[i]) |=> !flags_q[i]);

    // R8
    no_spurious_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (!flags_q[i] && !set_vec[i]) |=> !flags_q[i]);
  end

  // R10
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_q == '0 && set_vec == '0) |=> !irq);

endmodule

// File: tb/tb_prescaled_timer.sv
`timescale 1ns/1ps
module tb_prescaled_timer;
  localparam int CW = 32;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic [NC-1:0] cap_in = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;

  prescaled_timer dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_in    (cap_in),
    .irq       (irq)
  );

  always #10 clk = ~clk;

  // Scoreboard queues
  logic [CW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_req = 1'b0;
  logic          rd_pend = 1'b0;

  always @(posedge clk) rd_pend <= rd_req;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [CW-1:0] e;
      string         t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input int a, input logic [CW-1:0] d);
    @(negedge clk);
    bus_addr  = 4'(a);
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int a, input logic [CW-1:0] e, input string t);
    @(negedge clk);
    bus_addr = 4'(a);
    bus_we   = 1'b0;
    rd_req   = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cap(input int idx, input logic v);
    @(negedge clk);
    cap_in[idx] = v;
  endtask

  task automatic chk_bit(input logic got, input logic e, input string t);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b", t, got, e);
    end
  endtask

  task automatic zero_counters();
    wr(1, 32'h2);
    wr(1, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_bit(irq, 1'b0, "R1 irq after reset");
    chk_bit(|bus_rdata, 1'b0, "R1 rdata after reset");
    for (int a = 0; a < 15; a++) rd(a, '0, "R1 register reset value");

    // R11 map and read-only capture
    wr(6, 32'hA5A5_0001);
    wr(9, 32'h0000_BEEF);
    rd(6, 32'hA5A5_0001, "R11 compare 0 readback");
    rd(9, 32'h0000_BEEF, "R11 compare 3 readback");
    wr(11, 32'hDEAD_BEEF);
    rd(11, '0, "R11 capture register ignores write");
    wr(3, 32'h7);
    rd(3, 32'h7, "R11 prescale readback");
    wr(3, 32'h0);

    // R2 hold
    wr(2, 32'h100);
    wr(4, 32'h3);
    rd(2, 32'h100, "R11 counter load");
    wr(1, 32'h3);
    idle(5);
    rd(2, '0, "R2 counter held at zero");
    rd(4, '0, "R2 prescale counter held at zero");
    wr(1, 32'h0);

    // R3 prescale divide by 3 over 31 active clocks
    wr(3, 32'h2);
    wr(1, 32'h1);
    idle(29);
    wr(1, 32'h0);
    rd(2, 32'd10, "R3 counter after 31 clocks");
    rd(4, 32'd1, "R3 prescale counter after 31 clocks");
    idle(5);
    rd(2, 32'd10, "R3 counter frozen while disabled");

    // R4 R5 compare 0 with event and zero, period 6
    wr(3, 32'h0);
    zero_counters();
    wr(6, 32'd5);
    wr(5, 32'h003);
    wr(1, 32'h1);
    idle(11);
    wr(1, 32'h0);
    rd(2, 32'd1, "R5 counter wraps to zero at compare");
    rd(0, 32'h1, "R4 compare 0 flag");
    chk_bit(irq, 1'b1, "R10 irq with flag set");
    wr(0, 32'h0);
    rd(0, 32'h1, "R9 writing zero keeps flag");
    wr(0, 32'h1);
    rd(0, 32'h0, "R9 flag cleared by one");
    chk_bit(irq, 1'b0, "R10 irq low with no flags");

    // R8 R5 compare 2 zero without event, period 3
    zero_counters();
    wr(8, 32'd2);
    wr(5, 32'h080);
    wr(1, 32'h1);
    idle(8);
    wr(1, 32'h0);
    rd(2, 32'd1, "R5 compare 2 wrap");
    rd(0, 32'h0, "R8 no flag without event bit");
    chk_bit(irq, 1'b0, "R8 irq stays low");

    // R6 compare 1 halt with event
    zero_counters();
    wr(7, 32'd3);
    wr(5, 32'h028);
    wr(1, 32'h1);
    idle(10);
    rd(1, 32'h0, "R6 run bit cleared by halt");
    rd(2, 32'd4, "R6 counter stops after match");
    rd(0, 32'h2, "R4 compare 1 flag");
    wr(0, 32'h2);
    wr(5, 32'h0);

    // R7 R8 capture
    wr(10, 32'h605);
    wr(2, 32'h1234);
    set_cap(0, 1'b1);
    idle(4);
    rd(11, 32'h1234, "R7 rising capture ch0");
    rd(0, 32'h10, "R8 capture ch0 flag");
    chk_bit(irq, 1'b1, "R10 irq from capture");
    wr(2, 32'h55);
    set_cap(0, 1'b0);
    idle(4);
    rd(11, 32'h1234, "R7 falling edge ignored on ch0");
    wr(2, 32'h77);
    set_cap(3, 1'b1);
    idle(4);
    rd(14, 32'h77, "R7 both edges rise ch3");
    wr(2, 32'h88);
    set_cap(3, 1'b0);
    idle(4);
    rd(14, 32'h88, "R7 both edges fall ch3");
    rd(0, 32'h10, "R8 ch3 load without event bit");

    // R9 event and clear in the same clock
    wr(2, 32'h99);
    set_cap(0, 1'b1);
    idle(1);
    wr(0, 32'h10);
    rd(0, 32'h10, "R9 event beats clear");
    rd(11, 32'h99, "R7 capture during clear");
    wr(0, 32'h10);
    rd(0, 32'h0, "R9 clear without event");
    chk_bit(irq, 1'b0, "R10 irq low at end");

    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule